// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block drains a ring of 64 transmit descriptors, each 128 bytes long, that sits in memory behind a simple 64-bit request/acknowledge port. Software fills slots and moves a write pointer. The engine owns the read pointer. For every slot it fetches the command header and sends the inline payload bytes to a byte-wide MAC stream. It then fetches and sends up to three external gather buffers.

When the MAC reports that a packet is finished, the engine overwrites the slot's header with a status word and bumps the read pointer. It also raises single-cycle events: packet sent, ring drained, and fatal abort. A transmit-enable input gates the walk. A fatal abort halts the engine until the enable is dropped.

Top module: `txring_gather`

## Requirements
- R1: After reset, `rptr` is 0, `mem_req` and `mac_valid` are low, and no event is asserted.
- R2: A header fetch begins only when `tx_en` is high, the engine is not halted, and `rptr != wptr`. An empty ring causes no memory request.
- R3: A slot sits at `RING_BASE + 128*rptr`, and its header is the 64-bit word at the slot start. Header fields:
  - bits [15:0]: inline byte count minus one.
  - bits [22:16]: byte offset into the data block, which starts at slot+8.
  - bit 23: interrupt request.
  - bit 24: stop-on-abort.
  - bits [27:25]: valid flags for gather pointers 1..3.
  - The inline bytes are sent first.
- R4: Bytes are fetched as aligned 64-bit words. The byte at address A is bits [8*(A%8)+7 : 8*(A%8)] of its word.
- R5: Gather pointer k (k = 1..3) is the word at slot + 8*k. Its bits [15:0] hold the length minus one, and bits [44:16] hold the byte start address. Valid buffers are sent in the order 1, 2, 3, and invalid ones are skipped. `mac_last` is high only on the final byte of the packet.
- R6: After the last byte, the first `mac_done` causes this status word to be written over the header:
  - bits [15:0]: bytes sent.
  - bits [19:16]: `mac_retries`.
  - bit 20: `mac_ok`.
  - bits [25:21]: `mac_abort`, with bits ordered too-long, underrun, excess collisions, excess deferrals, late collision (LSB first).
  - bit 63: 1.
  - All other bits: 0.
- R7: `rptr` advances by one, modulo 64, in the cycle after the status write is acknowledged, and at no other time.
- R8: `evt_pkt_sent` pulses with the pointer advance when the header's interrupt-request bit was set.
- R9: `evt_ring_empty` pulses with the pointer advance when the new `rptr` equals `wptr`.
- R10: If stop-on-abort is set and `mac_abort` is nonzero, `evt_abort` pulses with the pointer advance and no further fetch occurs until `tx_en` has been low. An abort without stop-on-abort does not halt the engine.
- R11: Clearing `tx_en` during a packet lets that packet finish and write back, and then the engine stops.
- R12: While `mem_req` is high and unacknowledged, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold. While `mac_valid` is high and `mac_ready` is low, `mac_data` and `mac_last` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable |
| wptr | input | PTR_W | Software write pointer |
| rptr | output | PTR_W | Ring read pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 64 | Read data |
| mac_valid | output | 1 | Byte available |
| mac_data | output | 8 | Byte |
| mac_last | output | 1 | Final byte of packet |
| mac_ready | input | 1 | MAC takes the byte |
| mac_done | input | 1 | Packet completion pulse |
| mac_ok | input | 1 | Sent successfully |
| mac_retries | input | 4 | Collision retry count |
| mac_abort | input | 5 | Abort cause flags |
| evt_pkt_sent | output | 1 | Packet-sent event |
| evt_ring_empty | output | 1 | Ring-drained event |
| evt_abort | output | 1 | Fatal abort event |

## Verification
- **Bytes:** each byte counts as transferred at the clock edge where `mac_valid` and `mac_ready` are both high. The MAC model decides `mac_ready` on the falling edge and records the byte on that same falling edge, so what it logs is exactly what that edge transfers.
- **Status and events:** the status word lands in memory on the falling edge on which the model acknowledges the write. `rptr` and all three events change on the next rising edge. The scoreboard waits for the first falling edge on which `rptr` shows the new value, and in that same half-cycle it checks the events and the written word.
- **Halt and stop cases:** a window of several dozen cycles is watched for any byte or pointer movement.

// File: rtl/txring_gather.sv
module txring_gather #(
  parameter int ADDR_W = 32,
  parameter int PTR_W = 6,
  parameter logic [ADDR_W-1:0] RING_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  rptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata,
  output logic              mac_valid,
  output logic [7:0]        mac_data,
  output logic              mac_last,
  input  logic              mac_ready,
  input  logic              mac_done,
  input  logic              mac_ok,
  input  logic [3:0]        mac_retries,
  input  logic [4:0]        mac_abort,
  output logic              evt_pkt_sent,
  output logic              evt_ring_empty,
  output logic              evt_abort
);
  localparam int SLOT_SHIFT = 7;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PTR, S_SEND, S_WAIT, S_WB} st_t;
  st_t st;

  logic [2:0]        cat_pend;
  logic [1:0]        cat_k;
  logic [ADDR_W-1:0] cur;
  logic [16:0]       rem;
  logic [63:0]       wbuf;
  logic              wvld;
  logic [15:0]       sent;
  logic [63:0]       status;
  logic              hdr_irq, hdr_term, abort_hit, halted;

  logic [ADDR_W-1:0] slot;
  logic [1:0]        nxt_k;
  logic              xfer;

  assign slot  = RING_BASE + ADDR_W'({rptr, {SLOT_SHIFT{1'b0}}});
  assign nxt_k = cat_pend[0] ? 2'd0 : (cat_pend[1] ? 2'd1 : 2'd2);

  assign mem_req   = (st == S_HDR) || (st == S_PTR) || (st == S_WB) || (st == S_SEND && !wvld);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = status;
  always_comb begin
    case (st)
      S_HDR:   mem_addr = slot;
      S_PTR:   mem_addr = slot + ADDR_W'(8 * (int'(cat_k) + 1));
      S_SEND:  mem_addr = {cur[ADDR_W-1:3], 3'b000};
      S_WB:    mem_addr = slot;
      default: mem_addr = '0;
    endcase
  end

  assign mac_valid = (st == S_SEND) && wvld;
  assign mac_data  = wbuf[8*cur[2:0] +: 8];
  assign mac_last  = (rem == 17'd1) && (cat_pend == 3'b000);
  assign xfer      = mac_valid && mac_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      rptr <= '0;
      cat_pend <= '0;
      cat_k <= '0;
      cur <= '0;
      rem <= '0;
      wbuf <= '0;
      wvld <= 1'b0;
      sent <= '0;
      status <= '0;
      hdr_irq <= 1'b0;
      hdr_term <= 1'b0;
      abort_hit <= 1'b0;
      halted <= 1'b0;
      evt_pkt_sent <= 1'b0;
      evt_ring_empty <= 1'b0;
      evt_abort <= 1'b0;
    end else begin
      evt_pkt_sent <= 1'b0;
      evt_ring_empty <= 1'b0;
      evt_abort <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!tx_en) halted <= 1'b0;
          if (tx_en && !halted && rptr != wptr) st <= S_HDR;
        end
        S_HDR: if (mem_ack) begin
          cur <= slot + ADDR_W'(8) + ADDR_W'(mem_rdata[22:16]);
          rem <= 17'(mem_rdata[15:0]) + 17'd1;
          hdr_irq <= mem_rdata[23];
          hdr_term <= mem_rdata[24];
          cat_pend <= mem_rdata[27:25];
          sent <= '0;
          wvld <= 1'b0;
          st <= S_SEND;
        end
        S_PTR: if (mem_ack) begin
          cur <= ADDR_W'(mem_rdata[44:16]);
          rem <= 17'(mem_rdata[15:0]) + 17'd1;
          cat_pend <= cat_pend & ~(3'b001 << cat_k);
          wvld <= 1'b0;
          st <= S_SEND;
        end
        S_SEND: begin
          if (!wvld && mem_ack) begin
            wbuf <= mem_rdata;
            wvld <= 1'b1;
          end
          if (xfer) begin
            cur <= cur + ADDR_W'(1);
            rem <= rem - 17'd1;
            sent <= sent + 16'd1;
            if (cur[2:0] == 3'd7 || rem == 17'd1) wvld <= 1'b0;
            if (rem == 17'd1) begin
              if (cat_pend != 3'b000) begin
                cat_k <= nxt_k;
                st <= S_PTR;
              end else begin
                st <= S_WAIT;
              end
            end
          end
        end
        S_WAIT: if (mac_done) begin
          status <= {1'b1, 37'd0, mac_abort, mac_ok, mac_retries, sent};
          abort_hit <= |mac_abort;
          st <= S_WB;
        end
        S_WB: if (mem_ack) begin
          rptr <= rptr + PTR_W'(1);
          evt_pkt_sent <= hdr_irq;
          evt_ring_empty <= (rptr + PTR_W'(1)) == wptr;
          if (hdr_term && abort_hit) begin
            evt_abort <= 1'b1;
            halted <= 1'b1;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R12
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mac_valid && !mac_ready |=> mac_valid && $stable(mac_data) && $stable(mac_last));

  // R7
  ptr_after_wb_chk: assert property (@(posedge clk) disable iff (rst)
    rptr != $past(rptr) |-> $past(mem_req && mem_we && mem_ack));

  // R8
  sent_evt_chk: assert property (@(posedge clk) disable iff (rst)
    evt_pkt_sent |-> rptr != $past(rptr));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    evt_abort |=> !mem_req);

  // R6
  wb_done_bit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[63]);
endmodule

// File: tb/sim_txring_gather.sv
module sim_txring_gather;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, tx_en;
  logic [5:0] wptr, rptr;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic mac_valid, mac_last, mac_ready, mac_done, mac_ok;
  logic [7:0] mac_data;
  logic [3:0] mac_retries;
  logic [4:0] mac_abort;
  logic evt_pkt_sent, evt_ring_empty, evt_abort;

  int checks = 0, fails = 0, cyc = 0;

  txring_gather u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wptr(wptr), .rptr(rptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mac_valid(mac_valid), .mac_data(mac_data), .mac_last(mac_last), .mac_ready(mac_ready),
    .mac_done(mac_done), .mac_ok(mac_ok), .mac_retries(mac_retries), .mac_abort(mac_abort),
    .evt_pkt_sent(evt_pkt_sent), .evt_ring_empty(evt_ring_empty), .evt_abort(evt_abort));

  always #(CLK_P/2) clk = ~clk;

  logic [63:0] mem [0:2047];
  logic [7:0]  exp_b [0:32767];
  logic        exp_l [0:32767];
  int eb_w = 0, eb_r = 0;
  int p_len [0:255], p_slot [0:255];
  bit p_irq [0:255], p_term [0:255], p_ok [0:255];
  logic [3:0] p_retry [0:255];
  logic [4:0] p_abort [0:255];
  int n_built = 0, n_mac = 0, dcount = 0, heap = 8192, wsw = 0;
  int req_viol = 0, quiet_bad = 0;
  bit prev_wait = 0;
  logic [31:0] prev_addr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_status(input int p);
    return {1'b1, 37'd0, p_abort[p], p_ok[p], p_retry[p], 16'(p_len[p])};
  endfunction

  task automatic setb(input int a, input logic [7:0] v);
    mem[a >> 3][8*(a & 7) +: 8] = v;
  endtask

  task automatic push(input int a, input logic [7:0] v);
    setb(a, v);
    exp_b[eb_w] = v;
    exp_l[eb_w] = 1'b0;
    eb_w++;
  endtask

  task automatic build(input int inl, input int off, input logic [2:0] cats,
                       input bit irq, input bit term, input logic [4:0] ab);
    int s, base, total, blen;
    s = wsw;
    base = s * 128;
    mem[s*16] = {36'd0, cats, term, irq, 7'(off), 16'(inl - 1)};
    total = inl;
    for (int i = 0; i < inl; i++) push(base + 8 + off + i, 8'($urandom));
    for (int k = 0; k < 3; k++) begin
      if (cats[k]) begin
        blen = 1 + int'($urandom % 20);
        if (heap + blen > 16300) heap = 8192;
        mem[s*16 + 1 + k] = {19'd0, 29'(heap), 16'(blen - 1)};
        for (int i = 0; i < blen; i++) push(heap + i, 8'($urandom));
        heap = heap + blen + int'($urandom % 5);
        total += blen;
      end else if (off >= 24) begin
        mem[s*16 + 1 + k] = {$urandom, $urandom};
      end
    end
    exp_l[eb_w - 1] = 1'b1;
    p_len[n_built] = total;
    p_slot[n_built] = s;
    p_irq[n_built] = irq;
    p_term[n_built] = term;
    p_abort[n_built] = ab;
    p_ok[n_built] = (ab == 5'd0);
    p_retry[n_built] = 4'($urandom);
    n_built++;
    wsw = (s + 1) % 64;
  endtask

  // memory model plus R12 hold monitor
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      prev_wait = 0;
    end else begin
      if (prev_wait && (!mem_req || mem_addr != prev_addr)) req_viol++;
      mem_ack = mem_req && ($urandom % 3 != 0);
      if (mem_ack) begin
        if (mem_we) mem[mem_addr[13:3]] = mem_wdata;
        else mem_rdata = mem[mem_addr[13:3]];
      end
      prev_wait = mem_req && !mem_ack;
      prev_addr = mem_addr;
    end
  end

  // MAC model
  always @(negedge clk) begin
    mac_done = 1'b0;
    if (rst) begin
      mac_ready = 1'b0;
      dcount = 0;
    end else begin
      if (dcount > 0) begin
        dcount--;
        if (dcount == 0) begin
          mac_done = 1'b1;
          mac_ok = p_ok[n_mac];
          mac_retries = p_retry[n_mac];
          mac_abort = p_abort[n_mac];
          n_mac++;
        end
      end
      mac_ready = ($urandom % 4) != 0;
      if (mac_valid && mac_ready) begin
        chk(mac_data == exp_b[eb_r], "R4 byte data", 64'(mac_data), 64'(exp_b[eb_r]));
        chk(mac_last == exp_l[eb_r], "R5 last flag", 64'(mac_last), 64'(exp_l[eb_r]));
        if (mac_last) dcount = 1 + int'($urandom % 4);
        eb_r++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check_pkt(input int p);
    int target, t;
    bit abort_exp;
    target = (p_slot[p] + 1) % 64;
    t = 0;
    while (rptr != 6'(target) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(rptr == 6'(target), "R7 pointer advance", 64'(rptr), 64'(target));
    chk(mem[p_slot[p]*16] == exp_status(p), "R6 status word", mem[p_slot[p]*16], exp_status(p));
    chk(evt_pkt_sent == p_irq[p], "R8 sent event", 64'(evt_pkt_sent), 64'(p_irq[p]));
    chk(evt_ring_empty == (6'(target) == wptr), "R9 empty event", 64'(evt_ring_empty), 64'(6'(target) == wptr));
    abort_exp = p_term[p] && (p_abort[p] != 0);
    chk(evt_abort == abort_exp, "R10 abort event", 64'(evt_abort), 64'(abort_exp));
  endtask

  task automatic watch_quiet(input int n, input logic [5:0] hold);
    quiet_bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mac_valid || mem_req || rptr != hold) quiet_bad++;
    end
  endtask

  initial begin
    int first, nb;
    void'($urandom(32'd4242));
    rst = 1'b1; tx_en = 1'b0; wptr = '0;
    mac_ok = 0; mac_retries = 0; mac_abort = 0; mac_done = 0; mac_ready = 0;
    mem_ack = 0; mem_rdata = '0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rptr == 0 && !mem_req && !mac_valid && !evt_pkt_sent && !evt_ring_empty && !evt_abort,
        "R1 reset state", {rptr, mem_req, mac_valid, evt_pkt_sent, evt_ring_empty, evt_abort}, 64'd0);

    tx_en = 1'b1;
    watch_quiet(20, 6'd0);
    chk(quiet_bad == 0, "R2 empty ring idle", 64'(quiet_bad), 64'd0);

    // inline-only packet at offset 0
    build(13, 0, 3'b000, 1'b1, 1'b0, 5'd0);
    wptr = 6'(wsw);
    check_pkt(0);
    chk(eb_r == 13, "R3 inline byte count", 64'(eb_r), 64'd13);

    // all three buffers, then a skip of the middle one
    build(7, 24, 3'b111, 1'b0, 1'b0, 5'd0);
    build(30, 40, 3'b101, 1'b1, 1'b0, 5'b00010);
    wptr = 6'(wsw);
    check_pkt(1);
    check_pkt(2);
    chk(eb_r == eb_w, "R5 gather totals", 64'(eb_r), 64'(eb_w));

    // random batches, enough to wrap the ring
    while (n_built < 90) begin
      first = n_built;
      nb = 1 + int'($urandom % 6);
      for (int i = 0; i < nb; i++)
        build(1 + int'($urandom % 60), 24 + int'($urandom % 37), 3'($urandom), 1'($urandom),
              1'b0, ($urandom % 5 == 0) ? 5'($urandom) : 5'd0);
      wptr = 6'(wsw);
      for (int p = first; p < n_built; p++) check_pkt(p);
    end

    // stop-on-abort halts until tx_en drops
    first = n_built;
    build(20, 30, 3'b010, 1'b0, 1'b1, 5'b00100);
    build(9, 30, 3'b000, 1'b1, 1'b0, 5'd0);
    wptr = 6'(wsw);
    check_pkt(first);
    watch_quiet(40, rptr);
    chk(quiet_bad == 0, "R10 halted after abort", 64'(quiet_bad), 64'd0);
    tx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    tx_en = 1'b1;
    check_pkt(first + 1);

    // tx_en dropped mid-packet
    first = n_built;
    build(60, 30, 3'b011, 1'b0, 1'b0, 5'd0);
    build(10, 30, 3'b000, 1'b0, 1'b0, 5'd0);
    wptr = 6'(wsw);
    while (!mac_valid) @(negedge clk);
    tx_en = 1'b0;
    check_pkt(first);
    watch_quiet(30, rptr);
    chk(quiet_bad == 0, "R11 stop after packet", 64'(quiet_bad), 64'd0);
    tx_en = 1'b1;
    check_pkt(first + 1);

    chk(req_viol == 0, "R12 request hold", 64'(req_viol), 64'd0);
    chk(eb_r == eb_w, "R3 all bytes delivered", 64'(eb_r), 64'(eb_w));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule